// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the control strobes of an asynchronous DRAM whenever the memory needs refresh. After reset it waits out a power-on pause and then runs a burst of wake-up cycles on its own. Only then does it report the memory as ready. In normal operation a free-running interval timer adds one refresh to a backlog at the average rate that the row count and retention window call for. While the backlog is non-zero and no cycle is running, the block raises a request to the host access controller. Each grant is answered with one CAS-before-RAS refresh, which the block drives itself.

A refresh cycle needs no address and no data. Because the DRAM takes the row from its internal counter, the block drives only the row strobe and the two byte-lane column strobes. The access controller may postpone refreshes up to a set backlog depth, and an urgent flag tells it when that depth is reached. If one more refresh period passes with the backlog still full, the retention window is taken as broken. The block then drops its ready flag, discards the backlog and repeats the wake-up burst without a new power-on pause.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ras_n`, `lcas_n` and `ucas_n` are high and `init_done`, `ref_req`, `ref_urgent` and `ref_busy` are low.
- R2: After reset is released, no strobe goes low for at least PAUSE_US × CLK_MHZ clock cycles.
- R3: After the pause the block runs exactly WAKE_CNT refresh cycles and then raises `init_done`.
- R4: While `init_done` is low, `grant` has no effect: `ref_req` stays low and no cycle beyond the wake-up burst is run.
- R5: In every refresh cycle both column strobes fall together and stay low for at least T_CSR cycles before `ras_n` falls. They stay low for at least T_CHR cycles after `ras_n` falls. `ras_n` stays low for at least T_RAS cycles and is high for at least T_RP cycles before each fall. `lcas_n` equals `ucas_n` at all times.
- R6: With `init_done` high, one refresh is added to the backlog every REF_WINDOW_US × CLK_MHZ / REF_ROWS cycles. The first `ref_req` rises that many cycles (±1) after `init_done` rises.
- R7: `ref_req` is high exactly when the backlog is non-zero, `init_done` is high and no cycle is running. While it is high it stays high until `grant` is seen. Holding `grant` high drains the backlog with exactly as many refresh cycles as were pending.
- R8: `ref_urgent` is high while the backlog equals MAX_BACKLOG and low below that.
- R9: When a refresh period ends with the backlog full, `init_done` falls and the backlog is cleared. WAKE_CNT wake-up cycles then run with no power-on pause before `init_done` rises again, and `ref_req` is low at that point.
- R10: Asserting reset at any time restarts the whole sequence, pause included.
- R11: `ref_busy` is high in every cycle in which any strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rst_n | input | 1 | Synchronous active-low reset |
| grant | input | 1 | Access controller yields the DRAM bus for one refresh |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| ref_req | output | 1 | Refresh pending and block idle |
| ref_urgent | output | 1 | Backlog at its maximum depth |
| ref_busy | output | 1 | A refresh or wake-up cycle is running |
| init_done | output | 1 | Power-up done; memory usable |

## Verification
The scheduling function is tried with backlogs of one, two, three, five and the maximum depth. These are built by withholding `grant` for a chosen number of refresh periods and then holding it until the request drops. The runs separate a correct count of cycles per drain, and they show the urgent flag rising at full depth and not before. Further runs hold `grant` high through power-up and through a forced wake-up, which shows refused grants adding no cycles. A full backlog left for one more period shows the wake-up repeated without the pause. A passive strobe monitor times every edge pair against the CAS-before-RAS ordering limits.

// File: rtl/dram_rfsh_pkg.sv
// Package: shared state encodings for the DRAM refresh sequencer.
package dram_rfsh_pkg;

    // Phases of one CAS-before-RAS refresh cycle.
    typedef enum logic [2:0] {
        ENG_IDLE,   // strobes high, waiting for start
        ENG_PRE,    // precharge: RAS and CAS high
        ENG_CSR,    // CAS low ahead of RAS
        ENG_HOLD,   // RAS low, CAS still held low
        ENG_RASLO   // RAS low, CAS released
    } eng_state_t;

    // Top-level sequencing phases.
    typedef enum logic [1:0] {
        SEQ_PAUSE,  // power-on pause, no strobes
        SEQ_WAKE,   // wake-up burst of refresh cycles
        SEQ_RUN     // normal operation, memory usable
    } seq_state_t;

endpackage

// File: rtl/rfsh_interval_timer.sv
// Module: rfsh_interval_timer
// Emits a one-cycle tick every PERIOD cycles while enabled. The count restarts
// from zero whenever the enable is low. Assumes PERIOD >= 2.
module rfsh_interval_timer #(
    parameter int PERIOD = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(PERIOD);
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] cnt;

    // Free-running modulo-PERIOD count, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)   cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/rfsh_backlog.sv
// Module: rfsh_backlog
// Counts owed refreshes from 0 up to MAX. An increment on a full counter with
// no decrement in the same cycle is reported as overflow and does not wrap.
// A clear takes priority. Assumes a decrement only comes when the count is
// non-zero; the counter guards against it anyway.
module rfsh_backlog #(
    parameter int MAX = 8,
    localparam int CW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          overflow
);
    localparam logic [CW-1:0] TOP = CW'(MAX);

    assign full     = (count == TOP);
    assign overflow = inc && full && !dec;

    // Saturating up/down count of postponed refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && !dec && !full) begin
            count <= count + 1'b1;
        end else if (dec && !inc && (count != '0)) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/cbr_strobe_engine.sv
// Module: cbr_strobe_engine
// Runs one CAS-before-RAS refresh per start pulse: precharge for T_RP cycles,
// CAS low for T_CSR cycles, then RAS low for T_RAS cycles. CAS stays low
// during the first T_CHR of those. Strobes are registered from the next state,
// so they change together with the state register. Assumes T_RAS > T_CHR and
// that start only comes while busy is low.
module cbr_strobe_engine
    import dram_rfsh_pkg::*;
#(
    parameter int T_RP  = 5,
    parameter int T_CSR = 2,
    parameter int T_CHR = 2,
    parameter int T_RAS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int RLO  = T_RAS - T_CHR;
    localparam int M1   = (T_RP > T_CSR) ? T_RP : T_CSR;
    localparam int M2   = (T_CHR > RLO) ? T_CHR : RLO;
    localparam int MAXT = (M1 > M2) ? M1 : M2;
    localparam int CNTW = $clog2(MAXT + 1);

    eng_state_t state, state_d;
    logic [CNTW-1:0] cnt, cnt_d;

    // Next phase and phase-length count.
    always_comb begin
        state_d = state;
        cnt_d   = (cnt != '0) ? cnt - 1'b1 : cnt;
        unique case (state)
            ENG_IDLE:  if (start) begin
                           state_d = ENG_PRE;
                           cnt_d   = CNTW'(T_RP - 1);
                       end
            ENG_PRE:   if (cnt == '0) begin
                           state_d = ENG_CSR;
                           cnt_d   = CNTW'(T_CSR - 1);
                       end
            ENG_CSR:   if (cnt == '0) begin
                           state_d = ENG_HOLD;
                           cnt_d   = CNTW'(T_CHR - 1);
                       end
            ENG_HOLD:  if (cnt == '0) begin
                           state_d = ENG_RASLO;
                           cnt_d   = CNTW'(RLO - 1);
                       end
            ENG_RASLO: if (cnt == '0) begin
                           state_d = ENG_IDLE;
                       end
            default:   state_d = ENG_IDLE;
        endcase
    end

    // Phase register and registered strobe decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE;
            cnt   <= '0;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            ras_n <= !((state_d == ENG_HOLD) || (state_d == ENG_RASLO));
            cas_n <= !((state_d == ENG_CSR)  || (state_d == ENG_HOLD));
        end
    end

    assign busy = (state != ENG_IDLE);
    assign done = (state == ENG_RASLO) && (cnt == '0);
endmodule

// File: rtl/dram_rfsh_seq.sv
// Module: dram_rfsh_seq (top)
// Power-up pause, wake-up burst and periodic refresh scheduling for an
// asynchronous DRAM. All timing is in clock cycles derived from CLK_MHZ.
// Assumes the access controller leaves RAS/CAS precharged when it grants,
// and keeps off the bus while init_done is low or ref_busy is high.
module dram_rfsh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int         CLK_MHZ       = 125,
    parameter int         PAUSE_US      = 200,
    parameter int         WAKE_CNT      = 8,
    parameter int         REF_WINDOW_US = 8000,
    parameter int         REF_ROWS      = 512,
    parameter int         MAX_BACKLOG   = 8,
    parameter int         T_RP          = 5,
    parameter int         T_CSR         = 2,
    parameter int         T_CHR         = 2,
    parameter int         T_RAS         = 8,
    parameter logic [1:0] LANE_MASK     = 2'b11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n,
    output logic ref_req,
    output logic ref_urgent,
    output logic ref_busy,
    output logic init_done
);
    localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
    localparam int REF_CYC   = (REF_WINDOW_US * CLK_MHZ) / REF_ROWS;
    localparam int PW        = $clog2(PAUSE_CYC);
    localparam int WW        = (WAKE_CNT > 1) ? $clog2(WAKE_CNT) : 1;
    localparam int CW        = $clog2(MAX_BACKLOG + 1);

    seq_state_t      seq;
    logic [PW-1:0]   pause_cnt;
    logic [WW-1:0]   wake_cnt;
    logic [CW-1:0]   pend_cnt;
    logic            run, tick, full, overflow;
    logic            eng_start, eng_busy, eng_done, eng_cas_n;
    logic [1:0]      cas_lane;

    assign run = (seq == SEQ_RUN);

    // Pause, wake-up and run sequencing; overflow sends run back to wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq       <= SEQ_PAUSE;
            pause_cnt <= '0;
            wake_cnt  <= '0;
        end else begin
            unique case (seq)
                SEQ_PAUSE: if (pause_cnt == PW'(PAUSE_CYC - 1)) begin
                               seq      <= SEQ_WAKE;
                               wake_cnt <= '0;
                           end else begin
                               pause_cnt <= pause_cnt + 1'b1;
                           end
                SEQ_WAKE:  if (eng_done) begin
                               if (wake_cnt == WW'(WAKE_CNT - 1)) seq <= SEQ_RUN;
                               else wake_cnt <= wake_cnt + 1'b1;
                           end
                SEQ_RUN:   if (overflow) begin
                               seq      <= SEQ_WAKE;
                               wake_cnt <= '0;
                           end
                default:   seq <= SEQ_PAUSE;
            endcase
        end
    end

    // Refresh-interval tick, running only in normal operation.
    rfsh_interval_timer #(.PERIOD(REF_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (run),
        .tick (tick)
    );

    // Owed-refresh count; cleared whenever the block is not in normal operation.
    rfsh_backlog #(.MAX(MAX_BACKLOG)) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!run),
        .inc     (tick),
        .dec     (eng_done && run),
        .count   (pend_cnt),
        .full    (full),
        .overflow(overflow)
    );

    // Wake-up cycles start by themselves; normal refreshes need a grant.
    assign eng_start = !eng_busy &&
                       ((seq == SEQ_WAKE) || (run && grant && (pend_cnt != '0)));

    cbr_strobe_engine #(
        .T_RP (T_RP),
        .T_CSR(T_CSR),
        .T_CHR(T_CHR),
        .T_RAS(T_RAS)
    ) u_engine (
        .clk  (clk),
        .rst_n(rst_n),
        .start(eng_start),
        .busy (eng_busy),
        .done (eng_done),
        .ras_n(ras_n),
        .cas_n(eng_cas_n)
    );

    // Byte-lane column strobes: enabled lanes follow the engine, others stay high.
    for (genvar i = 0; i < 2; i++) begin : g_lane
        if (LANE_MASK[i]) begin : g_on
            assign cas_lane[i] = eng_cas_n;
        end else begin : g_off
            assign cas_lane[i] = 1'b1;
        end
    end

    assign lcas_n     = cas_lane[0];
    assign ucas_n     = cas_lane[1];
    assign init_done  = run;
    assign ref_req    = run && (pend_cnt != '0) && !eng_busy;
    assign ref_urgent = run && full;
    assign ref_busy   = eng_busy;
endmodule

// File: rtl/dram_rfsh_seq_chk.sv
// Module: dram_rfsh_seq_chk
// Property checker bound to dram_rfsh_seq. It watches strobe ordering, grant
// handling and the backlog bound. It drives nothing.
module dram_rfsh_seq_chk #(
    parameter int MAXB = 8,
    parameter int CW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          grant,
    input logic          ras_n,
    input logic          lcas_n,
    input logic          ucas_n,
    input logic          ref_req,
    input logic          ref_busy,
    input logic          init_done,
    input logic [CW-1:0] pend_cnt
);
    // R5: a column strobe is already low in the cycle before RAS falls.
    a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !$past(lcas_n && ucas_n));

    // R5: a column strobe is still low one cycle after RAS falls.
    a_r5_cas_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> !(lcas_n && ucas_n));

    // R5: RAS stays high for more than one cycle after it rises.
    a_r5_ras_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);

    // R11: strobes low only while a cycle is running.
    a_r11_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_busy |-> (ras_n && lcas_n && ucas_n));

    // R4: in normal operation a cycle starts only after a grant.
    a_r4_grant_needed: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ref_busy) && init_done) |-> $past(grant));

    // R7: an ungranted request is held.
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !grant) |=> (ref_req || !init_done));

    // R8: backlog never exceeds its depth.
    a_r8_backlog_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= CW'(MAXB));
endmodule

bind dram_rfsh_seq dram_rfsh_seq_chk #(
    .MAXB(MAX_BACKLOG),
    .CW  (CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .ras_n    (ras_n),
    .lcas_n   (lcas_n),
    .ucas_n   (ucas_n),
    .ref_req  (ref_req),
    .ref_busy (ref_busy),
    .init_done(init_done),
    .pend_cnt (pend_cnt)
);

// File: tb/dram_rfsh_seq_tb.sv
`timescale 1ns/1ps
module dram_rfsh_seq_tb;
    localparam int CLK_MHZ = 125;
    localparam int PAUSE_US = 2;
    localparam int WAKE = 8;
    localparam int WIN_US = 1024;
    localparam int ROWS = 512;
    localparam int MAXB = 8;
    localparam int TRP = 5, TCSR = 2, TCHR = 2, TRAS = 8;
    localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;          // 250
    localparam int REF_CYC = WIN_US * CLK_MHZ / ROWS;       // 250
    // backlog to build, expected urgent flag, expected refresh cycles on drain
    localparam int VEC [5][3] = '{'{1,0,1}, '{2,0,2}, '{3,0,3}, '{5,0,5}, '{8,1,8}};

    logic clk = 0, rst_n = 0, grant = 0;
    logic ras_n, lcas_n, ucas_n, ref_req, ref_urgent, ref_busy, init_done;
    int checks = 0, fails = 0, cyc = 0, ras_falls = 0;
    int ras_hi_run = 0, ras_lo_run = 0, cas_pre_run = 0, cas_post_run = 0;
    bit prev_ras = 1, prev_cas = 1, lane_bad = 0, busy_bad = 0;

    always #4 clk = ~clk;

    dram_rfsh_seq #(
        .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .WAKE_CNT(WAKE),
        .REF_WINDOW_US(WIN_US), .REF_ROWS(ROWS), .MAX_BACKLOG(MAXB),
        .T_RP(TRP), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .LANE_MASK(2'b11)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .grant(grant), .ras_n(ras_n), .lcas_n(lcas_n),
        .ucas_n(ucas_n), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .ref_busy(ref_busy), .init_done(init_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe timing monitor (R5, R11), sampled between clock edges.
    always @(negedge clk) begin
        bit cas;
        cyc++;
        cas = !(lcas_n && ucas_n) ? 1'b0 : 1'b1;
        if (!rst_n) begin
            ras_hi_run = 0; ras_lo_run = 0; cas_pre_run = 0; cas_post_run = 0;
            prev_ras = 1; prev_cas = 1;
        end else begin
            if (lcas_n != ucas_n) lane_bad = 1;
            if ((!ras_n || !cas) && !ref_busy) busy_bad = 1;
            if (prev_ras && !ras_n) begin
                ras_falls++;
                chk(cas_pre_run >= TCSR && !cas, "R5 cas setup before ras", cas_pre_run, TCSR);
                chk(ras_hi_run >= TRP, "R5 ras precharge", ras_hi_run, TRP);
            end
            if (!prev_ras && ras_n)
                chk(ras_lo_run >= TRAS, "R5 ras low width", ras_lo_run, TRAS);
            if (!ras_n && !prev_cas && cas)
                chk(cas_post_run >= TCHR, "R5 cas hold after ras", cas_post_run, TCHR);
            if (ras_n) begin
                ras_hi_run++; ras_lo_run = 0; cas_post_run = 0;
                cas_pre_run = cas ? 0 : cas_pre_run + 1;
            end else begin
                ras_lo_run++; ras_hi_run = 0; cas_pre_run = 0;
                if (!cas) cas_post_run++;
            end
            prev_ras = ras_n; prev_cas = cas;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
        finish_run();
    end

    // Reset, pause and wake-up; grant level held through init.
    task automatic powerup(input bit g, input string tag);
        int t0, f0, t_first, n;
        bit req_seen;
        rst_n = 0; grant = g;
        repeat (3) step();
        chk(ras_n && lcas_n && ucas_n && !init_done && !ref_req && !ref_urgent && !ref_busy,
            {tag, " R1 reset outputs"}, {ras_n, lcas_n, ucas_n, init_done, ref_req, ref_urgent, ref_busy}, 7'b1110000);
        rst_n = 1;
        step();
        chk(ras_n && lcas_n && ucas_n && !init_done && !ref_busy, {tag, " R1 first cycle"}, init_done, 0);
        t0 = cyc; f0 = ras_falls; t_first = -1; req_seen = 0;
        for (int i = 0; i < 3000 && !init_done; i++) begin
            step();
            if (t_first < 0 && ras_falls != f0) t_first = cyc;
            if (ref_req) req_seen = 1;
        end
        chk(t_first - t0 >= PAUSE_CYC, {tag, " R2 pause length"}, t_first - t0, PAUSE_CYC);
        chk(ras_falls - f0 == WAKE, {tag, " R3 wake-up cycles"}, ras_falls - f0, WAKE);
        chk(init_done && !req_seen, {tag, " R4 grant refused during init"}, req_seen, 0);
        grant = 0; n = 0;
        while (!ref_req && n < 2 * REF_CYC) begin step(); n++; end
        chk(n >= REF_CYC && n <= REF_CYC + 1, {tag, " R6 first request interval"}, n, REF_CYC);
    endtask

    task automatic drain();
        grant = 1;
        for (int i = 0; i < 1000; i++) begin
            step();
            if (!ref_req && !ref_busy) break;
        end
        grant = 0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 2 * REF_CYC && !ref_req; i++) step();
    endtask

    initial begin
        int f0, n;
        powerup(1'b1, "R10 cold");

        // Table of backlog depths.
        for (int v = 0; v < 5; v++) begin
            drain();
            wait_req();
            repeat ((VEC[v][0] - 1) * REF_CYC + 20) step();
            chk(ref_req == 1'b1, "R6 request pending", ref_req, 1);
            chk(ref_urgent == VEC[v][1][0], "R8 urgent at depth", ref_urgent, VEC[v][1]);
            f0 = ras_falls;
            drain();
            chk(ras_falls - f0 == VEC[v][2], "R7 cycles per drain", ras_falls - f0, VEC[v][2]);
            repeat (5) step();
            chk(!ref_busy && ras_n && !ref_req, "R7 idle after drain", ref_busy, 0);
        end

        // Overflow of the backlog forces a repeated wake-up.
        drain();
        wait_req();
        repeat ((MAXB - 1) * REF_CYC + 20) step();
        chk(ref_urgent, "R8 urgent before overflow", ref_urgent, 1);
        n = 0;
        while (init_done && n < 2 * REF_CYC) begin step(); n++; end
        chk(!init_done && n < REF_CYC, "R9 init_done falls on overflow", init_done, 0);
        f0 = ras_falls; grant = 1; n = 0;
        while (!init_done && n < 3000) begin step(); n++; end
        grant = 0;
        chk(ras_falls - f0 == WAKE, "R9 rewake cycle count (R4 grant ignored)", ras_falls - f0, WAKE);
        chk(n < PAUSE_CYC, "R9 no pause on rewake", n, PAUSE_CYC);
        chk(!ref_req, "R9 backlog cleared", ref_req, 0);

        // Reset in mid-operation restarts everything.
        repeat (100) step();
        powerup(1'b0, "R10 warm");

        chk(!lane_bad, "R5 lane strobes equal", lane_bad, 0);
        chk(!busy_bad, "R11 busy covers strobes", busy_bad, 0);
        finish_run();
    end
endmodule